// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the register and command front end of one 8-input programmable interrupt controller. A host reaches it through two byte-wide ports chosen by a single address bit. Address 0 is the command port and address 1 is the data port. A write lands on the rising clock edge when both chip select and the write strobe are high. The read bus is combinational: it follows the address bit and the stored state.

Before the block accepts operational commands, software runs an initialization sequence of two to four words. The first word, written to the command port, records whether the controller runs alone and whether a final fourth word follows. The later words go to the data port. The second word becomes the interrupt vector base. The third word (cascade wiring) and the fourth word (mode) advance the sequencer but are not stored.

Once the sequence is complete, the command port accepts two kinds of command:
- end-of-interrupt commands, which clear bits in the in-service register held here;
- a read-select command, which chooses whether a command-port read returns the request status or the in-service status.

A data-port write made while idle or ready loads the interrupt mask. The request status comes in from the priority logic outside the block. In-service bits are set from outside through a set vector and cleared here by end-of-interrupt commands.

Sequencer states and transitions:
- SEQ_WAIT_ICW1: the reset state.
- SEQ_WAIT_ICW2: entered from any state by a command write with bit 4 set.
- SEQ_WAIT_ICW3: entered after the second word when the single bit is 0.
- SEQ_WAIT_ICW4: entered after the second word when the single bit is 1 and the fourth-word bit is 1, or after the third word when the fourth-word bit is 1.
- SEQ_READY: entered otherwise after the second or third word, and always after the fourth word.

Top module: `pic_prog_if`

## Requirements
- R1: After reset the sequencer is in SEQ_WAIT_ICW1, and the mask, vector base and in-service register are 0x00. The read select is "request", so a command-port read returns `req_i`.
- R2: A command-port write with bit 4 set starts initialization in any state. Its bit 0 (fourth word follows) and bit 1 (single controller) are captured. The next data-port write is stored as the vector base on `vec_base_o`.
- R3: After the second word, the sequencer goes to SEQ_WAIT_ICW3 if the single bit is 0. Otherwise it goes to SEQ_WAIT_ICW4 if the fourth-word bit is 1. Otherwise it goes to SEQ_READY.
- R4: After the third word, the sequencer goes to SEQ_WAIT_ICW4 if the fourth-word bit is 1, otherwise to SEQ_READY. After the fourth word it always goes to SEQ_READY.
- R5: A data-port write loads the mask only in SEQ_WAIT_ICW1 or SEQ_READY. In the other three states the mask is left unchanged.
- R6: A data-port read always returns the mask.
- R7: In SEQ_READY, a command write with bits 4:3 = 00 and bits 7:5 = 011 is a specific end-of-interrupt. It clears the in-service bit whose index is given by bits 2:0.
- R8: In SEQ_READY, a command write with bits 4:3 = 00 and bits 7:5 = 001 is a non-specific end-of-interrupt. It clears only the lowest-numbered set in-service bit, and does nothing when none is set.
- R9: Any other value of bits 7:5 in a command write with bits 4:3 = 00 leaves the in-service register, mask and read select unchanged.
- R10: In SEQ_READY, a command write with bits 4:3 = 01 loads the read select from bits 1:0. A command-port read then returns `req_i` for select 10, the in-service register for select 11, and 0x00 for select 00 or 01.
- R11: Nothing changes unless chip select and write strobe are both high. A command write with bit 4 clear is ignored outside SEQ_READY.
- R12: Bits set in `svc_set_i` are set in the in-service register on the next edge. A set wins over a clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 = command port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| req_i | input | 8 | Request status from the priority logic |
| svc_set_i | input | 8 | In-service bits to set |
| svc_o | output | 8 | In-service register |
| mask_o | output | 8 | Interrupt mask register |
| vec_base_o | output | 8 | Vector base from the second initialization word |

## Verification
The hardest case to reach is a non-specific end-of-interrupt that arrives in the same cycle as a set of the bit it would clear, on a controller that has just been initialized down one particular path. The stimulus walks all four combinations of the single and fourth-word bits. It pre-loads the in-service register through `svc_set_i`, switches the read select to in-service, and then issues the end-of-interrupt with the set vector asserted in that same cycle. A behavioural model in the bench predicts every output and the read bus after each edge.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        SEQ_WAIT_ICW1,
        SEQ_WAIT_ICW2,
        SEQ_WAIT_ICW3,
        SEQ_WAIT_ICW4,
        SEQ_READY
    } seq_state_e;

    // command byte decode positions
    localparam int unsigned INIT_BIT    = 4;
    localparam int unsigned KIND_LO     = 3;
    localparam int unsigned IC4_BIT     = 0;
    localparam int unsigned SNGL_BIT    = 1;

    // end-of-interrupt opcodes in bits 7:5 (R, SL, EOI)
    localparam logic [2:0] OP_EOI_SPEC  = 3'b011;
    localparam logic [2:0] OP_EOI_NSPEC = 3'b001;

    localparam logic [1:0] KIND_OCW2    = 2'b00;
    localparam logic [1:0] KIND_OCW3    = 2'b01;

    localparam logic [1:0] SEL_REQ      = 2'b10;
    localparam logic [1:0] SEL_SVC      = 2'b11;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_prog_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output seq_state_e        state_o,
    output logic [DATA_W-1:0] vec_base_o
);

    seq_state_e state_q, state_d;
    logic       ic4_q;
    logic       sngl_q;
    logic       init_cmd;

    assign init_cmd = cmd_wr_i && wdata_i[INIT_BIT];

    always_comb begin
        state_d = state_q;
        if (init_cmd) begin
            state_d = SEQ_WAIT_ICW2;
        end else if (data_wr_i) begin
            unique case (state_q)
                SEQ_WAIT_ICW2: begin
                    if (!sngl_q)     state_d = SEQ_WAIT_ICW3;
                    else if (ic4_q)  state_d = SEQ_WAIT_ICW4;
                    else             state_d = SEQ_READY;
                end
                SEQ_WAIT_ICW3: state_d = ic4_q ? SEQ_WAIT_ICW4 : SEQ_READY;
                SEQ_WAIT_ICW4: state_d = SEQ_READY;
                SEQ_WAIT_ICW1: state_d = SEQ_WAIT_ICW1;
                SEQ_READY:     state_d = SEQ_READY;
                default:       state_d = SEQ_WAIT_ICW1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_WAIT_ICW1;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic4_q      <= 1'b0;
            sngl_q     <= 1'b0;
            vec_base_o <= '0;
        end else begin
            if (init_cmd) begin
                ic4_q  <= wdata_i[IC4_BIT];
                sngl_q <= wdata_i[SNGL_BIT];
            end
            if (data_wr_i && state_q == SEQ_WAIT_ICW2 && !init_cmd)
                vec_base_o <= wdata_i;
        end
    end

    assign state_o = state_q;

    AST_INIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> state_q == SEQ_WAIT_ICW2); // R2
    AST_SINGLE_SKIPS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && state_q == SEQ_WAIT_ICW2 && sngl_q) |=> state_q != SEQ_WAIT_ICW3); // R3
    AST_FOURTH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && !cmd_wr_i && state_q == SEQ_WAIT_ICW4) |=> state_q == SEQ_READY); // R4

endmodule

// File: rtl/pic_svc_reg.sv
module pic_svc_reg #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LVL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoi_spec_i,
    input  logic              eoi_nspec_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [DATA_W-1:0] set_i,
    output logic [DATA_W-1:0] svc_o
);

    logic [DATA_W-1:0] svc_q;
    logic [DATA_W-1:0] lowest;
    logic [DATA_W-1:0] clr;

    // isolate lowest set bit
    always_comb begin
        lowest = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (svc_q[i]) lowest = DATA_W'(1) << i;
        end
    end

    always_comb begin
        clr = '0;
        if (eoi_spec_i)       clr = DATA_W'(1) << level_i;
        else if (eoi_nspec_i) clr = lowest;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= (svc_q & ~clr) | set_i;
    end

    assign svc_o = svc_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (svc_q & $past(set_i)) == $past(set_i)); // R12
    AST_NO_STRAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (svc_q & ~$past(svc_q) & ~$past(set_i)) == '0); // R7
    AST_NSPEC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_nspec_i && set_i == '0) |=> $countones(svc_q ^ $past(svc_q)) <= 1); // R8

endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
    import pic_prog_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned LVL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] req_i,
    input  logic [DATA_W-1:0] svc_set_i,
    output logic [DATA_W-1:0] svc_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] vec_base_o
);

    seq_state_e state;
    logic       wr_en, cmd_wr, data_wr;
    logic       ready, ocw2_wr, ocw3_wr;
    logic       eoi_spec, eoi_nspec;
    logic [1:0] sel_q;
    logic [DATA_W-1:0] mask_q;

    assign wr_en   = cs_i && wr_i;
    assign cmd_wr  = wr_en && !addr_i;
    assign data_wr = wr_en && addr_i;
    assign ready   = (state == SEQ_READY);

    assign ocw2_wr   = ready && cmd_wr && (wdata_i[INIT_BIT:KIND_LO] == KIND_OCW2);
    assign ocw3_wr   = ready && cmd_wr && (wdata_i[INIT_BIT:KIND_LO] == KIND_OCW3);
    assign eoi_spec  = ocw2_wr && (wdata_i[DATA_W-1:DATA_W-3] == OP_EOI_SPEC);
    assign eoi_nspec = ocw2_wr && (wdata_i[DATA_W-1:DATA_W-3] == OP_EOI_NSPEC);

    pic_init_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_i   (cmd_wr),
        .data_wr_i  (data_wr),
        .wdata_i    (wdata_i),
        .state_o    (state),
        .vec_base_o (vec_base_o)
    );

    pic_svc_reg #(.DATA_W(DATA_W)) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoi_spec_i  (eoi_spec),
        .eoi_nspec_i (eoi_nspec),
        .level_i     (wdata_i[LVL_W-1:0]),
        .set_i       (svc_set_i),
        .svc_o       (svc_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sel_q  <= SEL_REQ;
        end else begin
            if (data_wr && (state == SEQ_WAIT_ICW1 || ready)) mask_q <= wdata_i;
            if (ocw3_wr) sel_q <= wdata_i[1:0];
        end
    end

    always_comb begin
        if (addr_i)                rdata_o = mask_q;
        else if (sel_q == SEL_REQ) rdata_o = req_i;
        else if (sel_q == SEL_SVC) rdata_o = svc_o;
        else                       rdata_o = '0;
    end

    assign mask_o = mask_q;

    AST_MASK_HELD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {SEQ_WAIT_ICW2, SEQ_WAIT_ICW3, SEQ_WAIT_ICW4}) |=> $stable(mask_q)); // R5
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && svc_set_i == '0) |=> ($stable(mask_q) && $stable(sel_q) && $stable(svc_o))); // R11
    AST_DATA_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i |-> rdata_o == mask_o); // R6

endmodule

// File: tb/test_pic_prog_if.sv
module test_pic_prog_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_i = 1'b0, wr_i = 1'b0, addr_i = 1'b0;
    logic [7:0] wdata_i = '0, req_i = '0, svc_set_i = '0;
    logic [7:0] rdata_o, svc_o, mask_o, vec_base_o;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference
    int m_state = 0;      // 0..4 : wait1, wait2, wait3, wait4, ready
    bit m_ic4 = 0, m_sngl = 0;
    int m_mask = 0, m_vec = 0, m_svc = 0, m_sel = 2;

    always #4 clk = ~clk;

    pic_prog_if i_pic_prog_if (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .req_i(req_i), .svc_set_i(svc_set_i),
        .svc_o(svc_o), .mask_o(mask_o), .vec_base_o(vec_base_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit c, bit w, bit a, int d, int s);
        bit cmdw, dataw;
        int clr, ns;
        @(negedge clk);
        cs_i = c; wr_i = w; addr_i = a; wdata_i = 8'(d); svc_set_i = 8'(s);
        cmdw  = c && w && !a;
        dataw = c && w && a;
        ns = m_state;
        clr = 0;
        if (cmdw && m_state == 4 && ((d >> 3) & 3) == 0) begin
            if (((d >> 5) & 7) == 3) clr = 1 << (d & 7);
            else if (((d >> 5) & 7) == 1) begin
                for (int i = 7; i >= 0; i--) if ((m_svc >> i) & 1) clr = 1 << i;
            end
        end
        if (cmdw && m_state == 4 && ((d >> 3) & 3) == 1) m_sel = d & 3;
        if (dataw && (m_state == 0 || m_state == 4)) m_mask = d & 255;
        if (cmdw && ((d >> 4) & 1)) begin
            m_ic4 = d[0]; m_sngl = d[1]; ns = 1;
        end else if (dataw) begin
            if (m_state == 1) begin
                m_vec = d & 255;
                ns = !m_sngl ? 2 : (m_ic4 ? 3 : 4);
            end else if (m_state == 2) ns = m_ic4 ? 3 : 4;
            else if (m_state == 3) ns = 4;
        end
        m_state = ns;
        m_svc = ((m_svc & ~clr) | s) & 255;
        @(posedge clk);
        #1;
        check(tag, "mask_o", int'(mask_o), m_mask);
        check(tag, "vec_base_o", int'(vec_base_o), m_vec);
        check(tag, "svc_o", int'(svc_o), m_svc);
        check(tag, "rdata_o", int'(rdata_o),
              a ? m_mask : (m_sel == 2 ? int'(req_i) : (m_sel == 3 ? m_svc : 0)));
    endtask

    task automatic cmd(string tag, int d);  step(tag, 1, 1, 0, d, 0); endtask
    task automatic dat(string tag, int d);  step(tag, 1, 1, 1, d, 0); endtask
    task automatic idle(string tag, bit a); step(tag, 0, 0, a, 8'h00, 0); endtask

    initial begin
        #1600000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        req_i = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state on both ports
        idle("R1", 0);
        idle("R1", 1);
        // R5 mask loads while waiting for the first word
        dat("R5", 8'h33);
        // R2 R3 R4: cascade with fourth word (single=0, ic4=1)
        cmd("R2", 8'h11);
        dat("R2", 8'h20);
        dat("R5", 8'h04);      // third word, mask held
        dat("R4", 8'h01);      // fourth word
        dat("R6", 8'hF0);      // ready: mask
        // R3 single, no fourth word -> ready at once
        cmd("R2", 8'h12);
        dat("R3", 8'h40);
        dat("R3", 8'h0F);
        // R3 single with fourth word
        cmd("R2", 8'h13);
        dat("R3", 8'h48);
        dat("R4", 8'h99);      // fourth word, not mask
        dat("R4", 8'h77);
        // R4 cascade, no fourth word
        cmd("R2", 8'h10);
        dat("R3", 8'h50);
        dat("R4", 8'h00);
        dat("R5", 8'h55);
        // R11 operational command outside ready is ignored
        cmd("R2", 8'h12);
        cmd("R11", 8'h0B);
        cmd("R11", 8'h20);
        dat("R11", 8'h60);
        idle("R11", 0);
        // R12 set in-service bits, R10 read in-service
        step("R12", 0, 0, 0, 0, 8'hA5);
        cmd("R10", 8'h0B);
        idle("R10", 0);
        cmd("R8", 8'h20);      // clears bit 0
        cmd("R7", 8'h67);      // clears bit 7
        cmd("R7", 8'h63);      // bit 3 not set: no change
        cmd("R9", 8'h40);
        cmd("R9", 8'hA0);
        cmd("R9", 8'hE2);
        cmd("R9", 8'h02);
        // R12 set wins against a non-specific clear of the same bit
        step("R12", 1, 1, 0, 8'h20, 8'h04);
        cmd("R8", 8'h20);
        cmd("R8", 8'h20);
        cmd("R8", 8'h20);      // empty: no change
        // R11 strobes must both be high
        step("R11", 0, 1, 1, 8'hEE, 0);
        step("R11", 1, 0, 1, 8'hEE, 0);
        step("R11", 0, 1, 0, 8'h0A, 0);
        idle("R11", 0);
        // R10 other selects
        cmd("R10", 8'h0A);
        req_i = 8'hC3;
        idle("R10", 0);
        cmd("R10", 8'h09);
        idle("R10", 0);
        cmd("R10", 8'h08);
        cmd("R10", 8'h0B);
        // R8 R7 walk over patterns
        for (int k = 0; k < 8; k++) begin
            step("R12", 0, 0, 0, 0, (8'h81 << (k % 4)) & 8'hFF);
            cmd("R8", 8'h20);
            cmd("R7", 8'h60 | k);
        end
        dat("R6", 8'hC8);
        idle("R6", 1);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule